// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of a peripheral controller reached through a two-byte I/O window. The byte at offset 0 is the index port and the byte at offset 1 is the data port. At reset the configuration space is closed. A host opens it by writing the opening key byte to the index port on two consecutive index writes. It closes it again by writing the closing key byte to the same port. While the space is open, an index write selects a register and data-port accesses then read or write that register. The index stays selected over any number of data accesses.

The register space has two levels. Indexes below a global limit (0x30 by default) are global registers and are always reachable. These are the device-select byte at 0x07, the identifier bytes at 0x20 and 0x21, and two writable option bytes at 0x1C and 0x27. Indexes at or above the limit are passed to the logical device named by the device-select byte, over a byte-wide register-file interface. That interface carries a device number, a register offset, a write strobe with data, and a read strobe with data returned in the same cycle.

The key detector is a three-state machine. The states are LOCKED, ARMED (one opening key seen) and OPEN. The transitions are:
- key_first: from LOCKED to ARMED on an index write of 0x87.
- key_second: from ARMED to OPEN on an index write of 0x87.
- key_broken: from ARMED to LOCKED on an index write of any other value.
- close: from OPEN to LOCKED on an index write of 0xAA.

Every other event leaves the state unchanged.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the space is LOCKED, the index latch holds 0x00, the device-select byte is 0x00, and a data-port read returns 0xFF.
- R2: The space becomes OPEN only after two consecutive index-port writes of 0x87. The write that completes the pair is not loaded into the index latch.
- R3: An index-port write of any value other than 0x87 between the two key bytes returns the detector to LOCKED, so a full new pair is needed.
- R4: An index-port write of 0xAA while OPEN returns the space to LOCKED and leaves the index latch unchanged.
- R5: While not OPEN, data-port reads and index-port reads return 0xFF. Data-port writes raise no downstream strobe and change no global register. Index writes do not load the index latch.
- R6: While OPEN, any index write other than 0xAA loads the index latch. The latch keeps its value across data-port reads and writes. An index-port read returns the latch.
- R7: Global index 0x07 is the device-select byte and reads back what was written. Its value drives the downstream device number.
- R8: Index 0x20 reads the high byte and index 0x21 reads the low byte of the 16-bit identifier (0x1061 by default).
- R9: Indexes below 0x30 never raise a downstream strobe, whatever device is selected. 0x1C and 0x27 are writable bytes that read back. Every other global index reads 0x00 and ignores writes.
- R10: While OPEN with index at or above 0x30, a data write raises the write strobe in the same cycle, carrying the selected device, the index and the data. A data read raises the read strobe and returns the device's read data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_addr | input | 1 | Window offset: 0 index port, 1 data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| ld_dev | output | 8 | Selected logical device number |
| ld_reg | output | 8 | Register offset inside the device |
| ld_wr | output | 1 | Device register write strobe |
| ld_wdata | output | 8 | Device register write byte |
| ld_rd | output | 1 | Device register read strobe |
| ld_rdata | input | 8 | Device register read byte, same cycle |

## Verification
The bench builds the block with its default parameters: keys 0x87 and 0xAA, identifier 0x1061 and a global limit of 0x30. With these values the random stream puts key bytes, global indexes and device indexes in the same small byte range. This lets broken key pairs, closing while a device register is selected, and device-select changes between device accesses all occur often. A stand-in device returns read bytes computed from the device number and offset, so a wrong routing of the select byte or the index shows up in the returned data.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    typedef enum logic [1:0] {
        CK_LOCKED = 2'd0,
        CK_ARMED  = 2'd1,
        CK_OPEN   = 2'd2
    } key_state_t;

    localparam logic PORT_INDEX = 1'b0;
    localparam logic PORT_DATA  = 1'b1;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_port_pkg::*;
#(
    parameter int              DW        = 8,
    parameter logic [DW-1:0]   KEY_OPEN  = 8'h87,
    parameter logic [DW-1:0]   KEY_CLOSE = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          is_open
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_LOCKED: if (idx_wr && wdata == KEY_OPEN) state_d = CK_ARMED;
            CK_ARMED: begin
                if (idx_wr) state_d = (wdata == KEY_OPEN) ? CK_OPEN : CK_LOCKED;
            end
            CK_OPEN:   if (idx_wr && wdata == KEY_CLOSE) state_d = CK_LOCKED;
            default:   state_d = CK_LOCKED;
        endcase
    end

    always_comb begin
        is_open = (state_q == CK_OPEN);
    end

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(idx_wr && wdata == KEY_OPEN && state_q == CK_ARMED));
    // R4
    close_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && idx_wr && wdata == KEY_CLOSE) |=> !is_open);
    // R3
    broken_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CK_ARMED && idx_wr && wdata != KEY_OPEN) |=> state_q == CK_LOCKED);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs #(
    parameter int            DW          = 8,
    parameter logic [DW-1:0] KEY_CLOSE   = 8'hAA,
    parameter logic [2*DW-1:0] CHIP_ID   = 16'h1061,
    parameter logic [DW-1:0] IDX_DEVSEL  = 8'h07,
    parameter logic [DW-1:0] IDX_OPT_A   = 8'h1C,
    parameter logic [DW-1:0] IDX_ID_HI   = 8'h20,
    parameter logic [DW-1:0] IDX_ID_LO   = 8'h21,
    parameter logic [DW-1:0] IDX_OPT_B   = 8'h27,
    parameter logic [DW-1:0] GLOBAL_LIM  = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_open,
    input  logic          idx_wr,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] index_q,
    output logic [DW-1:0] devsel_q,
    output logic          is_global,
    output logic [DW-1:0] glob_rdata
);
    localparam logic [DW-1:0] ID_HI = CHIP_ID[2*DW-1:DW];
    localparam logic [DW-1:0] ID_LO = CHIP_ID[DW-1:0];

    logic [DW-1:0] opt_a_q, opt_b_q;
    logic          glob_wr;

    assign is_global = (index_q < GLOBAL_LIM);
    assign glob_wr   = is_open && dat_wr && is_global;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (is_open && idx_wr && wdata != KEY_CLOSE) begin
            index_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel_q <= '0;
            opt_a_q  <= '0;
            opt_b_q  <= '0;
        end else if (glob_wr) begin
            if (index_q == IDX_DEVSEL) devsel_q <= wdata;
            if (index_q == IDX_OPT_A)  opt_a_q  <= wdata;
            if (index_q == IDX_OPT_B)  opt_b_q  <= wdata;
        end
    end

    always_comb begin
        glob_rdata = '0;
        if (index_q == IDX_DEVSEL) glob_rdata = devsel_q;
        if (index_q == IDX_OPT_A)  glob_rdata = opt_a_q;
        if (index_q == IDX_OPT_B)  glob_rdata = opt_b_q;
        if (index_q == IDX_ID_HI)  glob_rdata = ID_HI;
        if (index_q == IDX_ID_LO)  glob_rdata = ID_LO;
    end

    // R6
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr) |=> $stable(index_q));
    // R5
    locked_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open) |=> $stable(index_q) && $stable(devsel_q));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import cfg_port_pkg::*;
#(
    parameter int              DW          = 8,
    parameter logic [DW-1:0]   KEY_OPEN    = 8'h87,
    parameter logic [DW-1:0]   KEY_CLOSE   = 8'hAA,
    parameter logic [2*DW-1:0] CHIP_ID     = 16'h1061,
    parameter logic [DW-1:0]   GLOBAL_LIM  = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic          io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic [DW-1:0] ld_dev,
    output logic [DW-1:0] ld_reg,
    output logic          ld_wr,
    output logic [DW-1:0] ld_wdata,
    output logic          ld_rd,
    input  logic [DW-1:0] ld_rdata
);
    localparam logic [DW-1:0] IDLE_BYTE = '1;

    logic          is_open, is_global;
    logic          idx_wr, dat_wr, dat_rd;
    logic [DW-1:0] index_q, devsel_q, glob_rdata;

    assign idx_wr = io_wr && (io_addr == PORT_INDEX);
    assign dat_wr = io_wr && (io_addr == PORT_DATA);
    assign dat_rd = io_rd && (io_addr == PORT_DATA);

    cfg_key_fsm #(
        .DW(DW), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata), .is_open(is_open)
    );

    cfg_global_regs #(
        .DW(DW), .KEY_CLOSE(KEY_CLOSE), .CHIP_ID(CHIP_ID), .GLOBAL_LIM(GLOBAL_LIM)
    ) u_glob (
        .clk(clk), .rst_n(rst_n), .is_open(is_open), .idx_wr(idx_wr),
        .dat_wr(dat_wr), .wdata(io_wdata), .index_q(index_q),
        .devsel_q(devsel_q), .is_global(is_global), .glob_rdata(glob_rdata)
    );

    assign ld_dev   = devsel_q;
    assign ld_reg   = index_q;
    assign ld_wdata = io_wdata;
    assign ld_wr    = is_open && dat_wr && !is_global;
    assign ld_rd    = is_open && dat_rd && !is_global;

    always_comb begin
        if (!is_open)                  io_rdata = IDLE_BYTE;
        else if (io_addr == PORT_INDEX) io_rdata = index_q;
        else if (is_global)            io_rdata = glob_rdata;
        else                           io_rdata = ld_rdata;
    end

    // R5
    locked_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open) |-> !ld_wr && !ld_rd);
    // R9
    global_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr || ld_rd) |-> ld_reg >= GLOBAL_LIM);
    // R10
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ld_wr, ld_rd}) <= 1 || (io_wr && io_rd));
endmodule

// File: tb/test_keyed_cfg_port.sv
module test_keyed_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata, ld_dev, ld_reg, ld_wdata, ld_rdata;
    logic       ld_wr, ld_rd;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state
    bit         m_open = 0, m_armed = 0;
    logic [7:0] m_idx = 0, m_dev = 0, m_opt_a = 0, m_opt_b = 0;

    always #10 clk = ~clk;

    keyed_cfg_port i_keyed_cfg_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_dev(ld_dev), .ld_reg(ld_reg),
        .ld_wr(ld_wr), .ld_wdata(ld_wdata), .ld_rd(ld_rd), .ld_rdata(ld_rdata)
    );

    function automatic logic [7:0] dev_byte(logic [7:0] d, logic [7:0] r);
        return d ^ {r[3:0], r[7:4]} ^ 8'h3C;
    endfunction

    assign ld_rdata = dev_byte(ld_dev, ld_reg);

    function automatic logic [7:0] exp_data_read();
        if (!m_open) return 8'hFF;
        if (m_idx >= 8'h30) return dev_byte(m_dev, m_idx);
        case (m_idx)
            8'h07: return m_dev;
            8'h1C: return m_opt_a;
            8'h27: return m_opt_b;
            8'h20: return 8'h10;
            8'h21: return 8'h61;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idx_write(logic [7:0] v);
        @(negedge clk);
        io_addr = 1'b0; io_wdata = v; io_wr = 1'b1;
        #2;
        chk("R5 no strobe on index write", {ld_wr, ld_rd}, 0);
        @(posedge clk);
        if (!m_open) begin
            if (v == 8'h87 && m_armed) begin m_open = 1; m_armed = 0; end
            else m_armed = (v == 8'h87);
        end else if (v == 8'hAA) m_open = 0;
        else m_idx = v;
        #1 io_wr = 1'b0;
    endtask

    task automatic dat_write(logic [7:0] v);
        bit exp_s;
        @(negedge clk);
        io_addr = 1'b1; io_wdata = v; io_wr = 1'b1;
        #2;
        exp_s = m_open && m_idx >= 8'h30;
        chk("R10 write strobe", ld_wr, exp_s);
        chk("R9 no read strobe on write", ld_rd, 0);
        if (exp_s) begin
            chk("R10 write device", ld_dev, m_dev);
            chk("R10 write offset", ld_reg, m_idx);
            chk("R10 write data", ld_wdata, v);
        end
        @(posedge clk);
        if (m_open && m_idx == 8'h07) m_dev = v;
        if (m_open && m_idx == 8'h1C) m_opt_a = v;
        if (m_open && m_idx == 8'h27) m_opt_b = v;
        #1 io_wr = 1'b0;
    endtask

    task automatic dat_read(string req);
        bit exp_s;
        @(negedge clk);
        io_addr = 1'b1; io_rd = 1'b1;
        #2;
        exp_s = m_open && m_idx >= 8'h30;
        chk(req, io_rdata, exp_data_read());
        chk("R10 read strobe", ld_rd, exp_s);
        chk("R9 no write strobe on read", ld_wr, 0);
        @(posedge clk);
        #1 io_rd = 1'b0;
    endtask

    task automatic idx_read(string req);
        @(negedge clk);
        io_addr = 1'b0; io_rd = 1'b1;
        #2;
        chk(req, io_rdata, m_open ? m_idx : 8'hFF);
        @(posedge clk);
        #1 io_rd = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        dat_read("R1 locked data read after reset");
        idx_read("R5 locked index read");
        // R3 broken key then fresh pair
        idx_write(8'h87); idx_write(8'h12); idx_write(8'h87);
        dat_read("R3 still locked after broken pair");
        idx_write(8'h87);
        idx_read("R1 R2 index zero after opening");
        // R8 identifier
        idx_write(8'h20); dat_read("R8 id high");
        idx_write(8'h21); dat_read("R8 id low");
        // R7 device select
        idx_write(8'h07); dat_read("R1 devsel reset zero");
        dat_write(8'h05); dat_read("R7 devsel readback");
        // R10 and R6 device access
        idx_write(8'h40);
        dat_write(8'h9A); dat_write(8'h3B);
        dat_read("R10 device read"); dat_read("R6 repeated device read");
        idx_read("R6 index kept across data access");
        // R9 globals
        idx_write(8'h1C); dat_write(8'h5E); dat_read("R9 option A readback");
        idx_write(8'h27); dat_write(8'hC3); dat_read("R9 option B readback");
        idx_write(8'h22); dat_write(8'h77); dat_read("R9 plain global reads zero");
        // R4 and R5 locking
        idx_write(8'h27);
        idx_write(8'hAA);
        dat_write(8'h11); dat_read("R5 locked data read");
        idx_write(8'h33); idx_read("R5 locked index read after write");
        idx_write(8'h87); idx_write(8'h87);
        idx_read("R4 index unchanged by close");
        dat_read("R5 locked write ignored");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 9);
            case ($urandom_range(0, 5))
                0: v = 8'h87;
                1: v = 8'hAA;
                2: v = 8'h07;
                3: v = 8'h1C + 8'($urandom_range(0, 11));
                default: v = 8'($urandom_range(0, 255));
            endcase
            if (op < 4) idx_write(v);
            else if (op < 6) dat_write(8'($urandom_range(0, 255)));
            else if (op < 9) dat_read("R10 random data read");
            else idx_read("R6 random index read");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule